// File: doc/BRIEF.md
# In-Order Load/Store Address Queue

This block accepts load and store operations from an issue stage and holds each in a circular queue entry. Every entry keeps a base operand, an address field and, for stores, a store-data operand. An operand is either a ready value (tag 0) or a tag naming the producer whose result will later appear on the result broadcast bus. Entries compare their tags with every broadcast and capture a matching value. The effective address of each entry is computed as base plus immediate. Addresses are formed strictly in issue order, so an entry cannot form its address until it is the oldest one whose address is still pending. Memory accesses against an internal synchronous word array also run in issue order, one per cycle.

A load reads its word and then offers it on the result port under its own tag, which is the slot number plus a fixed tag base. The load keeps that offer unchanged until the downstream bus owner grants it, and it frees its entry on the grant. A store waits until its data operand is resolved, writes the word, and frees its entry at once. Issue allocates the slot at the tail and stalls when that slot is still occupied.

Top module: `lsq_unit`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1, `res_valid` is 0 and `iss_tag` equals TAG_BASE (8 by default), which is slot 0.
- R2: Slots are allocated in circular order 0,1,..,DEPTH-1,0,..; an accepted issue reports tag TAG_BASE+slot on `iss_tag`. `iss_ready` is 0 while the tail slot is occupied, and an issue offered then is ignored: no entry is taken and `iss_tag` does not move.
- R3: The memory word index is the low AW bits of (base value + immediate), with carries above bit AW-1 discarded.
- R4: Address formation follows issue order. A younger entry whose base is ready does not access memory while an older entry still waits on its base tag.
- R5: A load's word appears on `res_data` with `res_tag` equal to its own tag. While `res_grant` is low, `res_valid`, `res_tag` and `res_data` hold unchanged. A grant frees the entry.
- R6: A store writes its data only once the data tag is resolved. Memory accesses happen in issue order, so a later load to the same word waits and returns the stored value.
- R7: An operand waiting on a nonzero tag takes `bus_data` when `bus_valid` is high and `bus_tag` equals that tag, including in the issue cycle itself. A broadcast with any other tag leaves the operand waiting. Tag 0 on an issue operand means the value field is already valid.
- R8: When no result is being held, the oldest load to obtain data is offered first. After each grant, the next offered load is the ready load in the lowest slot index.
- R9: After reset all memory words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_base_tag | input | TW | Base producer tag, 0 = ready |
| iss_base_val | input | DW | Base value when tag is 0 |
| iss_data_tag | input | TW | Store-data producer tag, 0 = ready |
| iss_data_val | input | DW | Store data when tag is 0 |
| iss_imm | input | DW | Immediate offset |
| iss_ready | output | 1 | Tail slot free, issue will be taken |
| iss_tag | output | TW | Tag the next accepted issue receives |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TW | Broadcast producer tag |
| bus_data | input | DW | Broadcast value |
| res_valid | output | 1 | Load result offered |
| res_tag | output | TW | Tag of offered load |
| res_data | output | DW | Loaded word |
| res_grant | input | 1 | Offered result accepted this cycle |

## Verification
The checks assume that the bus never broadcasts tag 0 and that producer tags on the bus never coincide with the queue's own tag range while a queue entry waits on them. They also assume that `res_grant` is raised only while `res_valid` is high. The directed tasks use producer tags 3 to 7 for outside results, keep TAG_BASE at 8, and grant only after they have seen an offered result. Each scenario drains the queue before the next one starts, so the bench can track the expected slot sequence by itself.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
// Shared types for the load/store queue.
// Assumes nothing beyond standard SystemVerilog packages.
package lsq_pkg;
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } lsq_op_e;
endpackage

// File: rtl/lsq_ptr.sv
`timescale 1ns/1ps
// Circular slot pointer: advances by one on adv, wraps after DEPTH-1.
// Assumes DEPTH >= 2.
module lsq_ptr #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    output logic [$clog2(DEPTH)-1:0] ptr
);
    localparam int IW = $clog2(DEPTH);

    // Step the pointer, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == IW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/lsq_pick.sv
`timescale 1ns/1ps
// Lowest-index priority picker over N request bits.
// Assumes idx is ignored when found is low.
module lsq_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lsq_mem.sv
`timescale 1ns/1ps
// Word memory: one write per cycle, combinational read, cleared on reset.
// Assumes the caller never reads and writes the same word in one cycle.
module lsq_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [AW-1:0] idx;
    logic          unused_hi;

    assign idx       = addr[AW-1:0];
    assign unused_hi = ^addr[DW-1:AW];
    assign rdata     = mem[idx];

    // Clear on reset, otherwise perform the requested write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/lsq_unit.sv
`timescale 1ns/1ps
// Load/store queue: address formation and memory access both in issue order,
// tag-based operand capture from the broadcast bus, load results offered with
// hold-until-grant. Assumes TAG_BASE > 0, DEPTH >= 2, and that the queue's own
// tags never appear on the bus while an entry waits on them.
module lsq_unit #(
    parameter int DEPTH    = 4,
    parameter int DW       = 16,
    parameter int AW       = 4,
    parameter int TW       = 4,
    parameter int TAG_BASE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_store,
    input  logic [TW-1:0] iss_base_tag,
    input  logic [DW-1:0] iss_base_val,
    input  logic [TW-1:0] iss_data_tag,
    input  logic [DW-1:0] iss_data_val,
    input  logic [DW-1:0] iss_imm,
    output logic          iss_ready,
    output logic [TW-1:0] iss_tag,
    input  logic          bus_valid,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_data,
    output logic          res_valid,
    output logic [TW-1:0] res_tag,
    output logic [DW-1:0] res_data,
    input  logic          res_grant
);
    import lsq_pkg::*;

    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0]    tail, ahead, mptr;
    logic [DEPTH-1:0] busy, adone, mdone, ld_rdy;
    lsq_op_e          kind [DEPTH];
    logic [TW-1:0]    qj [DEPTH];
    logic [TW-1:0]    qk [DEPTH];
    logic [DW-1:0]    vj [DEPTH];
    logic [DW-1:0]    vk [DEPTH];
    logic [DW-1:0]    ea [DEPTH];
    logic [DW-1:0]    ldat [DEPTH];

    logic          alloc, addr_go, mem_go, mem_we, retire;
    logic [TW-1:0] in_qj, in_qk;
    logic [DW-1:0] in_vj, in_vk, mem_rdata;
    logic          pick_found, hold_v;
    logic [IW-1:0] pick_idx, hold_idx, sel_idx;

    assign iss_ready = !busy[tail];
    assign iss_tag   = TW'(TAG_BASE) + TW'(tail);
    assign alloc     = iss_valid && iss_ready;

    // Issue operands, with same-cycle capture of a matching broadcast.
    always_comb begin
        in_qj = iss_base_tag;
        in_vj = iss_base_val;
        in_qk = iss_data_tag;
        in_vk = iss_data_val;
        if (iss_base_tag != '0 && bus_valid && bus_tag == iss_base_tag) begin
            in_qj = '0;
            in_vj = bus_data;
        end
        if (iss_data_tag != '0 && bus_valid && bus_tag == iss_data_tag) begin
            in_qk = '0;
            in_vk = bus_data;
        end
        if (!iss_store) in_qk = '0;
    end

    // Address step for the oldest entry whose address is pending.
    assign addr_go = busy[ahead] && !adone[ahead] && (qj[ahead] == '0);

    // Memory step for the oldest entry whose access is pending.
    assign mem_go = busy[mptr] && adone[mptr] && !mdone[mptr] &&
                    (kind[mptr] == OP_LOAD || qk[mptr] == '0);
    assign mem_we = mem_go && (kind[mptr] == OP_STORE);

    lsq_ptr #(.DEPTH(DEPTH)) u_tail  (.clk(clk), .rst_n(rst_n), .adv(alloc),   .ptr(tail));
    lsq_ptr #(.DEPTH(DEPTH)) u_ahead (.clk(clk), .rst_n(rst_n), .adv(addr_go), .ptr(ahead));
    lsq_ptr #(.DEPTH(DEPTH)) u_mptr  (.clk(clk), .rst_n(rst_n), .adv(mem_go),  .ptr(mptr));

    lsq_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ea[mptr]),
        .wdata (vk[mptr]),
        .rdata (mem_rdata)
    );

    lsq_pick #(.N(DEPTH)) u_pick (.req(ld_rdy), .found(pick_found), .idx(pick_idx));

    assign sel_idx   = hold_v ? hold_idx : pick_idx;
    assign res_valid = hold_v || pick_found;
    assign res_tag   = TW'(TAG_BASE) + TW'(sel_idx);
    assign res_data  = ldat[sel_idx];
    assign retire    = res_valid && res_grant;

    // Keep the offered result fixed until it is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold_v   <= res_valid && !res_grant;
            hold_idx <= sel_idx;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign ld_rdy[i] = busy[i] && mdone[i] && (kind[i] == OP_LOAD);

        // Entry state: allocate, snoop the bus, address step, memory step, retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[i]  <= 1'b0;
                adone[i] <= 1'b0;
                mdone[i] <= 1'b0;
                kind[i]  <= OP_LOAD;
                qj[i]    <= '0;
                qk[i]    <= '0;
            end else if (alloc && tail == IW'(i)) begin
                busy[i]  <= 1'b1;
                adone[i] <= 1'b0;
                mdone[i] <= 1'b0;
                kind[i]  <= iss_store ? OP_STORE : OP_LOAD;
                ea[i]    <= iss_imm;
                qj[i]    <= in_qj;
                vj[i]    <= in_vj;
                qk[i]    <= in_qk;
                vk[i]    <= in_vk;
            end else begin
                if (busy[i] && qj[i] != '0 && bus_valid && bus_tag == qj[i]) begin
                    qj[i] <= '0;
                    vj[i] <= bus_data;
                end
                if (busy[i] && qk[i] != '0 && bus_valid && bus_tag == qk[i]) begin
                    qk[i] <= '0;
                    vk[i] <= bus_data;
                end
                if (addr_go && ahead == IW'(i)) begin
                    ea[i]    <= vj[i] + ea[i];
                    adone[i] <= 1'b1;
                end
                if (mem_go && mptr == IW'(i)) begin
                    if (kind[i] == OP_STORE) begin
                        busy[i] <= 1'b0;
                    end else begin
                        mdone[i] <= 1'b1;
                        ldat[i]  <= mem_rdata;
                    end
                end
                if (retire && sel_idx == IW'(i)) begin
                    busy[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/lsq_unit_chk.sv
`timescale 1ns/1ps
// Port-level checker for lsq_unit, bound into every instance.
// Assumes rst_n is low at the first clock edge.
module lsq_unit_chk #(
    parameter int DEPTH    = 4,
    parameter int TW       = 4,
    parameter int DW       = 16,
    parameter int TAG_BASE = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [TW-1:0] iss_tag,
    input logic          res_valid,
    input logic [TW-1:0] res_tag,
    input logic [DW-1:0] res_data,
    input logic          res_grant
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (iss_ready && !res_valid));

    // R2
    tag_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (iss_tag != $past(iss_tag)));

    // R2
    tag_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |=> $stable(iss_tag));

    // R5
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_grant) |=>
            (res_valid && $stable(res_tag) && $stable(res_data)));

    // R5
    res_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag >= TW'(TAG_BASE) && res_tag < TW'(TAG_BASE + DEPTH)));
endmodule

bind lsq_unit lsq_unit_chk #(
    .DEPTH(DEPTH), .TW(TW), .DW(DW), .TAG_BASE(TAG_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_data  (res_data),
    .res_grant (res_grant)
);

// File: tb/lsq_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for lsq_unit: one task per scenario.
module lsq_unit_tb;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int TW    = 4;
    localparam int TB    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, iss_store = 1'b0;
    logic [TW-1:0] iss_base_tag = '0, iss_data_tag = '0;
    logic [DW-1:0] iss_base_val = '0, iss_data_val = '0, iss_imm = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [DW-1:0] bus_data = '0;
    logic          res_valid;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;
    logic          res_grant = 1'b0;

    int total = 0;
    int bad = 0;
    int exp_slot = 0;
    int last_slot = 0;
    bit accepted;

    always #10 clk = ~clk;

    lsq_unit #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .TW(TW), .TAG_BASE(TB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_store(iss_store),
        .iss_base_tag(iss_base_tag), .iss_base_val(iss_base_val),
        .iss_data_tag(iss_data_tag), .iss_data_val(iss_data_val),
        .iss_imm(iss_imm), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .res_grant(res_grant)
    );

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Offer one issue (optionally with a same-cycle broadcast); checks R2 slot tag.
    task automatic issue_bus(input logic st, input int bt, input int bv,
                             input int dt, input int dv, input int imm,
                             input logic bv_en, input int btg, input int bdat);
        @(negedge clk);
        iss_valid = 1'b1; iss_store = st;
        iss_base_tag = TW'(bt); iss_base_val = DW'(bv);
        iss_data_tag = TW'(dt); iss_data_val = DW'(dv); iss_imm = DW'(imm);
        bus_valid = bv_en; bus_tag = TW'(btg); bus_data = DW'(bdat);
        #1;
        accepted = iss_ready;
        if (accepted) begin
            chk("R2 issue tag", int'(iss_tag), TB + exp_slot);
            last_slot = exp_slot;
            exp_slot = (exp_slot + 1) % DEPTH;
        end
        @(posedge clk);
        #1;
        iss_valid = 1'b0; bus_valid = 1'b0;
    endtask

    task automatic issue(input logic st, input int bt, input int bv,
                         input int dt, input int dv, input int imm);
        issue_bus(st, bt, bv, dt, dv, imm, 1'b0, 0, 0);
    endtask

    task automatic bcast(input int t, input int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_tag = TW'(t); bus_data = DW'(d);
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    // Expect no result offer for n cycles.
    task automatic quiet(input int n, input string r);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (res_valid) seen = 1;
        end
        chk(r, seen, 0);
    endtask

    // Wait for an offered result, check it, grant it.
    task automatic take(input int etag, input int edata, input string r);
        int k = 0;
        @(negedge clk);
        while (!res_valid && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk({r, " valid"}, int'(res_valid), 1);
        chk({r, " tag"}, int'(res_tag), etag);
        chk({r, " data"}, int'(res_data), edata);
        res_grant = 1'b1;
        @(posedge clk);
        #1;
        res_grant = 1'b0;
    endtask

    // Drain n loads: oldest first, then ascending slot (R8).
    task automatic drain(input int slots[4], input int n, input int edata, input string r);
        int left[4];
        for (int k = 0; k < 4; k++) left[k] = (k < n) ? 1 : 0;
        take(TB + slots[0], edata, r);
        left[0] = 0;
        for (int m = 1; m < n; m++) begin
            int best = -1;
            for (int k = 0; k < n; k++)
                if (left[k] != 0 && (best < 0 || slots[k] < slots[best])) best = k;
            take(TB + slots[best], edata, r);
            left[best] = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ready", int'(iss_ready), 1);
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 tag", int'(iss_tag), TB);
    endtask

    task automatic t_zero_mem();
        issue(1'b0, 0, 0, 0, 0, 7);
        take(TB + last_slot, 0, "R9 cleared word");
    endtask

    task automatic t_store_load();
        issue(1'b1, 0, 3, 0, 16'hBEEF, 2);
        issue(1'b0, 0, 1, 0, 0, 4);
        take(TB + last_slot, 16'hBEEF, "R3 R6 store then load");
        issue(1'b0, 0, 16'h00F0, 0, 0, 16'h0015);
        take(TB + last_slot, 16'hBEEF, "R3 carry dropped");
    endtask

    task automatic t_bus_base();
        issue(1'b0, 6, 0, 0, 0, 1);
        bcast(7, 4);
        quiet(5, "R7 other tag ignored");
        bcast(6, 4);
        take(TB + last_slot, 16'hBEEF, "R7 base from bus");
        issue_bus(1'b0, 6, 0, 0, 0, 1, 1'b1, 6, 4);
        take(TB + last_slot, 16'hBEEF, "R7 same-cycle capture");
    endtask

    task automatic t_order();
        int sa, sb;
        issue(1'b0, 3, 0, 0, 0, 0);
        sa = last_slot;
        issue(1'b0, 0, 2, 0, 0, 0);
        sb = last_slot;
        quiet(6, "R4 younger waits");
        bcast(3, 5);
        take(TB + sa, 16'hBEEF, "R4 older first");
        take(TB + sb, 0, "R4 younger next");
    endtask

    task automatic t_store_wait();
        issue(1'b1, 0, 0, 5, 0, 9);
        issue(1'b0, 0, 0, 0, 0, 9);
        quiet(6, "R6 load behind pending store");
        bcast(5, 16'h1234);
        take(TB + last_slot, 16'h1234, "R6 load sees store");
    endtask

    task automatic t_hold();
        int t0, d0;
        issue(1'b0, 0, 9, 0, 0, 0);
        idle(4);
        @(negedge clk);
        chk("R5 offered", int'(res_valid), 1);
        t0 = int'(res_tag); d0 = int'(res_data);
        chk("R5 own tag", t0, TB + last_slot);
        idle(3);
        @(negedge clk);
        chk("R5 still valid", int'(res_valid), 1);
        chk("R5 tag held", int'(res_tag), t0);
        chk("R5 data held", int'(res_data), d0);
        take(t0, 16'h1234, "R5 granted");
        @(negedge clk);
        chk("R5 freed", int'(res_valid), 0);
    endtask

    task automatic t_prio();
        int s[4];
        for (int k = 0; k < 3; k++) begin
            issue(1'b0, 0, 5, 0, 0, 0);
            s[k] = last_slot;
        end
        s[3] = 0;
        idle(10);
        drain(s, 3, 16'hBEEF, "R8 priority");
    endtask

    task automatic t_full();
        int s[4];
        int tag_before;
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 4, 0, 0, 0, 9);
            s[k] = last_slot;
        end
        @(negedge clk);
        chk("R2 full not ready", int'(iss_ready), 0);
        tag_before = int'(iss_tag);
        issue(1'b0, 0, 0, 0, 0, 5);
        chk("R2 ignored when full", int'(accepted), 0);
        chk("R2 tag unmoved", int'(iss_tag), tag_before);
        bcast(4, 0);
        idle(12);
        drain(s, 4, 16'h1234, "R8 full drain");
        quiet(4, "R2 rejected issue left no entry");
        @(negedge clk);
        chk("R2 ready after drain", int'(iss_ready), 1);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_zero_mem();
        t_store_load();
        t_bus_base();
        t_order();
        t_store_wait();
        t_hold();
        t_prio();
        t_full();
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule